// File: doc/BRIEF.md
# Low-Power Stop Sequencer

This block moves a small microcontroller from normal running into one of three stop depths when the CPU raises a one-cycle stop request, and brings it back out again. The depth comes from two configuration bits: a power-down bit and a partial bit. The low-voltage monitor settings can override that choice. For each depth the block drives separate enables for the core, RAM retention, regulator standby, clock generator, converter standby and the periodic wake timer. Analog parts appear only as these enable levels.

The block captures the I/O pin output values on entry to the two shallower depths and keeps driving them to the pins. After the middle depth these held values stay in force until software writes a 1 to an acknowledge bit. The deepest depth switches off RAM and forces the low-voltage indication active. It wakes only on the reset or IRQ pin and leaves through a power-on-reset request. That request is withheld until the supply is flagged as above its rearm level. The middle depth wakes through a wake-up reset. The shallow depth wakes through a wake interrupt and needs no reset.

Top module: `stop_seq`

## Requirements
- R1: While reset is asserted and after it, the block is in the run state. core_on, ram_on, clk_on and timer_on are 1. core_stby, reg_stby, conv_stby, lvd_flag, hold_en, por_req and wake_irq are 0. pin_drv is 0 during reset. In run without hold, pin_drv follows port_out one cycle later.
- R2: A stop_req accepted in run takes effect on the next cycle. The depth is chosen as follows: cfg_pwrdn=1 and cfg_partial=0 selects deep stop; cfg_pwrdn=1 and cfg_partial=1 selects middle stop; cfg_pwrdn=0 selects shallow stop whatever cfg_partial is.
- R3: When lvd_en and lvd_stop_en are both 1, a request for deep or middle stop enters shallow stop instead.
- R4: In deep stop, core_on, ram_on, clk_on, timer_on and hold_en are 0. reg_stby, conv_stby and lvd_flag are 1.
- R5: Deep stop wakes only on rst_pin_n=0 or irq_pin=0. IRQ is taken as active low whatever irq_pol_high and irq_en are set to. timer_tick has no effect.
- R6: A deep-stop wake completes only on a cycle with supply_ok=1. Until then the deep-stop outputs are held, including lvd_flag=1. On completion the block returns to run and raises por_req for exactly one cycle.
- R7: In middle stop, core_on, core_stby, clk_on and lvd_flag are 0. ram_on, reg_stby and conv_stby are 1. timer_on equals timer_keep as sampled with the request.
- R8: On entry to middle or shallow stop, hold_en becomes 1 and pin_drv takes the port_out value present with the request. pin_drv then ignores changes on port_out while hold_en is 1.
- R9: Middle stop wakes on any of these: rst_pin_n=0; irq_en=1 with irq_pin at the configured polarity (irq_pol_high=1 means high is active); timer_tick=1 while the timer is kept. The block returns to run with a one-cycle por_req, and hold_en stays 1.
- R10: In run with hold_en=1, ack_wr=1 with ack_data=1 clears hold_en on the next cycle, and pin_drv returns to port_out. An acknowledge written with ack_data=0 has no effect, and so does one written during a stop.
- R11: In shallow stop, core_stby, ram_on, reg_stby and conv_stby are 1, and core_on and lvd_flag are 0. clk_on equals osc_keep and timer_on equals timer_keep, both as sampled with the request.
- R12: Shallow stop wakes on the same sources as middle stop. It returns to run with wake_irq high for exactly one cycle, no por_req, and hold_en cleared at the same time. timer_tick is ignored when the timer was not kept.
- R13: stop_req is ignored outside the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| cfg_pwrdn | input | 1 | Power-down configuration bit |
| cfg_partial | input | 1 | Partial power-down configuration bit |
| lvd_en | input | 1 | Low-voltage detect enable |
| lvd_stop_en | input | 1 | Low-voltage detect kept on in stop |
| rst_pin_n | input | 1 | Reset pin, active low |
| irq_pin | input | 1 | IRQ pin level |
| irq_pol_high | input | 1 | Configured IRQ polarity, 1 = active high |
| irq_en | input | 1 | IRQ wake enable |
| osc_keep | input | 1 | Keep crystal oscillator running in shallow stop |
| timer_keep | input | 1 | Keep the periodic wake timer running in stop |
| timer_tick | input | 1 | Periodic wake timer tick |
| supply_ok | input | 1 | Supply is above the rearm level |
| ack_wr | input | 1 | Acknowledge register write strobe |
| ack_data | input | 1 | Acknowledge write data |
| port_out | input | PIN_W | Port register output values |
| core_on | output | 1 | Core, peripherals and flash running |
| core_stby | output | 1 | Core held in standby |
| ram_on | output | 1 | RAM powered or retained |
| reg_stby | output | 1 | Regulator in low-power standby |
| clk_on | output | 1 | Clock generator running |
| conv_stby | output | 1 | Converter in standby |
| timer_on | output | 1 | Periodic wake timer running |
| lvd_flag | output | 1 | Forced low-voltage indication |
| por_req | output | 1 | Power-on / wake-up reset request pulse |
| wake_irq | output | 1 | Wake interrupt pulse |
| hold_en | output | 1 | Pin hold active |
| pin_drv | output | PIN_W | Values driven to the pins |

## Verification
All outputs are registered. A request, a wake source, a supply recovery or an acknowledge that is present at a rising edge shows its effect in the cycle that starts at that edge. Inputs are changed on the falling edge, and each result is sampled at the following falling edge, exactly one edge later. A delayed deep-stop exit is checked once at the edge that holds the wait and once at the edge that sees supply_ok. The one-cycle pulses por_req and wake_irq are checked high at that sample and low at the sample after it.

// File: rtl/stop_pkg.sv
package stop_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DEEP   = 3'd1,
    ST_DWAIT  = 3'd2,
    ST_MID    = 3'd3,
    ST_SHAL   = 3'd4
  } st_e;

  typedef enum logic [1:0] {
    LV_DEEP = 2'd1,
    LV_MID  = 2'd2,
    LV_SHAL = 2'd3
  } lvl_e;

  typedef struct packed {
    logic core_on;
    logic core_stby;
    logic ram_on;
    logic reg_stby;
    logic clk_on;
    logic conv_stby;
    logic timer_on;
    logic lvd_flag;
  } pwr_t;

  localparam pwr_t PWR_RUN = '{core_on: 1'b1, core_stby: 1'b0, ram_on: 1'b1,
                               reg_stby: 1'b0, clk_on: 1'b1, conv_stby: 1'b0,
                               timer_on: 1'b1, lvd_flag: 1'b0};

  function automatic pwr_t pwr_of(st_e st, logic osc, logic tmr);
    pwr_t p;
    p = PWR_RUN;
    case (st)
      ST_DEEP, ST_DWAIT: begin
        p = '{core_on: 1'b0, core_stby: 1'b0, ram_on: 1'b0, reg_stby: 1'b1,
              clk_on: 1'b0, conv_stby: 1'b1, timer_on: 1'b0, lvd_flag: 1'b1};
      end
      ST_MID: begin
        p = '{core_on: 1'b0, core_stby: 1'b0, ram_on: 1'b1, reg_stby: 1'b1,
              clk_on: 1'b0, conv_stby: 1'b1, timer_on: tmr, lvd_flag: 1'b0};
      end
      ST_SHAL: begin
        p = '{core_on: 1'b0, core_stby: 1'b1, ram_on: 1'b1, reg_stby: 1'b1,
              clk_on: osc, conv_stby: 1'b1, timer_on: tmr, lvd_flag: 1'b0};
      end
      default: p = PWR_RUN;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/stop_lvl_pick.sv
module stop_lvl_pick
  import stop_pkg::*;
(
  input  logic cfg_pwrdn,
  input  logic cfg_partial,
  input  logic lvd_en,
  input  logic lvd_stop_en,
  output lvl_e lvl
);
  logic lvd_live;

  always_comb begin
    lvd_live = lvd_en & lvd_stop_en;
    if (!cfg_pwrdn || lvd_live) begin
      lvl = LV_SHAL;
    end else if (cfg_partial) begin
      lvl = LV_MID;
    end else begin
      lvl = LV_DEEP;
    end
  end
endmodule

// File: rtl/stop_wake_mux.sv
module stop_wake_mux (
  input  logic rst_pin_n,
  input  logic irq_pin,
  input  logic irq_pol_high,
  input  logic irq_en,
  input  logic timer_tick,
  input  logic tmr_kept,
  output logic wake_deep,
  output logic wake_light
);
  logic irq_hit;

  always_comb begin
    wake_deep  = !rst_pin_n || !irq_pin;
    irq_hit    = irq_en && (irq_pol_high ? irq_pin : !irq_pin);
    wake_light = !rst_pin_n || irq_hit || (timer_tick && tmr_kept);
  end
endmodule

// File: rtl/stop_pwr_map.sv
module stop_pwr_map
  import stop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_e  st_next,
  input  logic osc_next,
  input  logic tmr_next,
  output pwr_t pwr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr <= PWR_RUN;
    end else begin
      pwr <= pwr_of(st_next, osc_next, tmr_next);
    end
  end
endmodule

// File: rtl/stop_pin_hold.sv
module stop_pin_hold #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic             rel,
  input  logic [PIN_W-1:0] port_out,
  output logic             hold_en,
  output logic [PIN_W-1:0] pin_drv
);
  logic hold_next;

  always_comb begin
    hold_next = cap || (hold_en && !rel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_en <= 1'b0;
    end else begin
      hold_en <= hold_next;
    end
  end

  for (genvar b = 0; b < PIN_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_drv[b] <= 1'b0;
      end else if (cap || !hold_next) begin
        pin_drv[b] <= port_out[b];
      end
    end
  end
endmodule

// File: rtl/stop_seq.sv
module stop_seq
  import stop_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic             cfg_pwrdn,
  input  logic             cfg_partial,
  input  logic             lvd_en,
  input  logic             lvd_stop_en,
  input  logic             rst_pin_n,
  input  logic             irq_pin,
  input  logic             irq_pol_high,
  input  logic             irq_en,
  input  logic             osc_keep,
  input  logic             timer_keep,
  input  logic             timer_tick,
  input  logic             supply_ok,
  input  logic             ack_wr,
  input  logic             ack_data,
  input  logic [PIN_W-1:0] port_out,
  output logic             core_on,
  output logic             core_stby,
  output logic             ram_on,
  output logic             reg_stby,
  output logic             clk_on,
  output logic             conv_stby,
  output logic             timer_on,
  output logic             lvd_flag,
  output logic             por_req,
  output logic             wake_irq,
  output logic             hold_en,
  output logic [PIN_W-1:0] pin_drv
);
  st_e  st_q, st_n;
  lvl_e lvl;
  logic osc_q, tmr_q, osc_n, tmr_n;
  logic wake_deep, wake_light;
  logic cap, rel, por_n, wirq_n, accept;
  pwr_t pwr;

  stop_lvl_pick i_pick (
    .cfg_pwrdn  (cfg_pwrdn),
    .cfg_partial(cfg_partial),
    .lvd_en     (lvd_en),
    .lvd_stop_en(lvd_stop_en),
    .lvl        (lvl)
  );

  stop_wake_mux i_wake (
    .rst_pin_n   (rst_pin_n),
    .irq_pin     (irq_pin),
    .irq_pol_high(irq_pol_high),
    .irq_en      (irq_en),
    .timer_tick  (timer_tick),
    .tmr_kept    (tmr_q),
    .wake_deep   (wake_deep),
    .wake_light  (wake_light)
  );

  always_comb begin
    accept = (st_q == ST_RUN) && stop_req;
    osc_n  = accept ? osc_keep   : osc_q;
    tmr_n  = accept ? timer_keep : tmr_q;
  end

  always_comb begin
    st_n   = st_q;
    cap    = 1'b0;
    rel    = 1'b0;
    por_n  = 1'b0;
    wirq_n = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (ack_wr && ack_data) begin
          rel = 1'b1;
        end
        if (stop_req) begin
          case (lvl)
            LV_DEEP: begin
              st_n = ST_DEEP;
              rel  = 1'b1;
            end
            LV_MID: begin
              st_n = ST_MID;
              cap  = 1'b1;
            end
            default: begin
              st_n = ST_SHAL;
              cap  = 1'b1;
            end
          endcase
        end
      end
      ST_DEEP: begin
        if (wake_deep) begin
          if (supply_ok) begin
            st_n  = ST_RUN;
            por_n = 1'b1;
          end else begin
            st_n = ST_DWAIT;
          end
        end
      end
      ST_DWAIT: begin
        if (supply_ok) begin
          st_n  = ST_RUN;
          por_n = 1'b1;
        end
      end
      ST_MID: begin
        if (wake_light) begin
          st_n  = ST_RUN;
          por_n = 1'b1;
        end
      end
      ST_SHAL: begin
        if (wake_light) begin
          st_n   = ST_RUN;
          wirq_n = 1'b1;
          rel    = 1'b1;
        end
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      osc_q    <= 1'b0;
      tmr_q    <= 1'b0;
      por_req  <= 1'b0;
      wake_irq <= 1'b0;
    end else begin
      st_q     <= st_n;
      osc_q    <= osc_n;
      tmr_q    <= tmr_n;
      por_req  <= por_n;
      wake_irq <= wirq_n;
    end
  end

  stop_pwr_map i_pwr (
    .clk     (clk),
    .rst     (rst),
    .st_next (st_n),
    .osc_next(osc_n),
    .tmr_next(tmr_n),
    .pwr     (pwr)
  );

  stop_pin_hold #(.PIN_W(PIN_W)) i_hold (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap),
    .rel     (rel),
    .port_out(port_out),
    .hold_en (hold_en),
    .pin_drv (pin_drv)
  );

  always_comb begin
    core_on   = pwr.core_on;
    core_stby = pwr.core_stby;
    ram_on    = pwr.ram_on;
    reg_stby  = pwr.reg_stby;
    clk_on    = pwr.clk_on;
    conv_stby = pwr.conv_stby;
    timer_on  = pwr.timer_on;
    lvd_flag  = pwr.lvd_flag;
  end
endmodule

// File: rtl/stop_seq_chk.sv
module stop_seq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         stop_req,
  input logic         lvd_en,
  input logic         lvd_stop_en,
  input logic         supply_ok,
  input logic         core_on,
  input logic         core_stby,
  input logic         ram_on,
  input logic         lvd_flag,
  input logic         por_req,
  input logic         wake_irq,
  input logic         hold_en,
  input logic [W-1:0] pin_drv
);
  assert_mode_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({core_on, core_stby, lvd_flag}));

  assert_lvd_guard_R3: assert property (@(posedge clk) disable iff (rst)
    (core_on && stop_req && lvd_en && lvd_stop_en) |=> (core_stby && !lvd_flag));

  assert_deep_ram_off_R4: assert property (@(posedge clk) disable iff (rst)
    lvd_flag |-> (!ram_on && !core_on));

  assert_deep_exit_supply_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(lvd_flag) |-> (por_req && $past(supply_ok)));

  assert_pins_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_en && $past(hold_en)) |-> $stable(pin_drv));

  assert_por_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    por_req |=> !por_req);

  assert_wake_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> (!por_req && !hold_en));
endmodule

bind stop_seq stop_seq_chk #(.W(PIN_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .stop_req   (stop_req),
  .lvd_en     (lvd_en),
  .lvd_stop_en(lvd_stop_en),
  .supply_ok  (supply_ok),
  .core_on    (core_on),
  .core_stby  (core_stby),
  .ram_on     (ram_on),
  .lvd_flag   (lvd_flag),
  .por_req    (por_req),
  .wake_irq   (wake_irq),
  .hold_en    (hold_en),
  .pin_drv    (pin_drv)
);

// File: tb/test_stop_seq.sv
module test_stop_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 0, cfg_pwrdn = 0, cfg_partial = 0, lvd_en = 0, lvd_stop_en = 0;
  logic rst_pin_n = 1, irq_pin = 1, irq_pol_high = 0, irq_en = 0;
  logic osc_keep = 0, timer_keep = 0, timer_tick = 0, supply_ok = 1;
  logic ack_wr = 0, ack_data = 0;
  logic [W-1:0] port_out = 8'h5A;
  logic core_on, core_stby, ram_on, reg_stby, clk_on, conv_stby, timer_on, lvd_flag;
  logic por_req, wake_irq, hold_en;
  logic [W-1:0] pin_drv;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_seq #(.PIN_W(W)) i_stop_seq (
    .clk(clk), .rst(rst), .stop_req(stop_req), .cfg_pwrdn(cfg_pwrdn),
    .cfg_partial(cfg_partial), .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en),
    .rst_pin_n(rst_pin_n), .irq_pin(irq_pin), .irq_pol_high(irq_pol_high),
    .irq_en(irq_en), .osc_keep(osc_keep), .timer_keep(timer_keep),
    .timer_tick(timer_tick), .supply_ok(supply_ok), .ack_wr(ack_wr),
    .ack_data(ack_data), .port_out(port_out), .core_on(core_on),
    .core_stby(core_stby), .ram_on(ram_on), .reg_stby(reg_stby),
    .clk_on(clk_on), .conv_stby(conv_stby), .timer_on(timer_on),
    .lvd_flag(lvd_flag), .por_req(por_req), .wake_irq(wake_irq),
    .hold_en(hold_en), .pin_drv(pin_drv)
  );

  // {core_on, core_stby, ram_on, reg_stby, clk_on, conv_stby, timer_on, lvd_flag}
  function automatic logic [7:0] exp_pwr(int lvl, bit osc, bit tmr);
    case (lvl)
      1:       return 8'b0001_0101;
      2:       return {6'b001101, tmr, 1'b0};
      3:       return {4'b0111, osc, 1'b1, tmr, 1'b0};
      default: return 8'b1010_1010;
    endcase
  endfunction

  function automatic int exp_lvl(bit pd, bit pp, bit le, bit lse);
    if (!pd || (le && lse)) return 3;
    if (pp) return 2;
    return 1;
  endfunction

  function automatic logic [7:0] act_pwr();
    return {core_on, core_stby, ram_on, reg_stby, clk_on, conv_stby, timer_on, lvd_flag};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_stop(bit pd, bit pp, bit le, bit lse, bit osc, bit tmr, output int lvl);
    cfg_pwrdn = pd; cfg_partial = pp; lvd_en = le; lvd_stop_en = lse;
    osc_keep = osc; timer_keep = tmr; stop_req = 1;
    tick();
    stop_req = 0;
    lvl = exp_lvl(pd, pp, le, lse);
    chk(act_pwr() == exp_pwr(lvl, osc, tmr), "R2 stop outputs", act_pwr(), exp_pwr(lvl, osc, tmr));
  endtask

  task automatic ack();
    ack_wr = 1; ack_data = 1;
    tick();
    ack_wr = 0; ack_data = 0;
  endtask

  initial begin
    int lvl;
    logic [W-1:0] held;
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    chk(act_pwr() == exp_pwr(0, 0, 0) && !hold_en && !por_req && !wake_irq && pin_drv == 0,
        "R1 reset state", {act_pwr(), pin_drv}, {exp_pwr(0, 0, 0), 8'h00});
    rst = 0;
    tick();
    chk(pin_drv == 8'h5A && act_pwr() == exp_pwr(0, 0, 0), "R1 run follows port", pin_drv, 8'h5A);

    // deep stop
    do_stop(1, 0, 0, 0, 1, 1, lvl);
    chk(act_pwr() == exp_pwr(1, 0, 0) && !hold_en, "R4 deep outputs", act_pwr(), exp_pwr(1, 0, 0));
    timer_tick = 1;
    tick();
    timer_tick = 0;
    chk(lvd_flag && !por_req, "R5 tick ignored in deep", {lvd_flag, por_req}, 2'b10);
    stop_req = 1;
    tick();
    stop_req = 0;
    chk(act_pwr() == exp_pwr(1, 0, 0), "R13 request ignored in stop", act_pwr(), exp_pwr(1, 0, 0));
    supply_ok = 0; irq_pol_high = 1; irq_en = 0; irq_pin = 0;
    tick();
    irq_pin = 1;
    chk(act_pwr() == exp_pwr(1, 0, 0) && !por_req, "R6 deep exit waits for supply", act_pwr(), exp_pwr(1, 0, 0));
    tick();
    chk(lvd_flag && !por_req, "R6 still waiting", {lvd_flag, por_req}, 2'b10);
    supply_ok = 1;
    tick();
    chk(por_req && act_pwr() == exp_pwr(0, 0, 0), "R6 por on supply ok", {por_req, act_pwr()}, {1'b1, exp_pwr(0, 0, 0)});
    irq_pol_high = 0;
    tick();
    chk(!por_req, "R6 por one cycle", por_req, 0);

    // middle stop
    port_out = 8'hC3;
    do_stop(1, 1, 0, 0, 0, 1, lvl);
    chk(act_pwr() == exp_pwr(2, 0, 1), "R7 middle outputs", act_pwr(), exp_pwr(2, 0, 1));
    port_out = 8'h11;
    tick();
    chk(hold_en && pin_drv == 8'hC3, "R8 pins held in middle", pin_drv, 8'hC3);
    timer_tick = 1;
    tick();
    timer_tick = 0;
    chk(por_req && core_on && hold_en && pin_drv == 8'hC3, "R9 middle wake keeps hold",
        {por_req, core_on, hold_en, pin_drv}, {3'b111, 8'hC3});
    ack_wr = 1; ack_data = 0;
    tick();
    ack_wr = 0;
    chk(hold_en && pin_drv == 8'hC3, "R10 ack data 0 ignored", pin_drv, 8'hC3);
    ack();
    chk(!hold_en && pin_drv == 8'h11, "R10 ack releases pins", {hold_en, pin_drv}, {1'b0, 8'h11});

    // guarded request falls to shallow
    port_out = 8'h3C;
    do_stop(1, 0, 1, 1, 1, 0, lvl);
    chk(act_pwr() == exp_pwr(3, 1, 0), "R3 guard gives shallow", act_pwr(), exp_pwr(3, 1, 0));
    chk(clk_on && core_stby, "R11 shallow clock kept", {clk_on, core_stby}, 2'b11);
    timer_tick = 1;
    tick();
    timer_tick = 0;
    chk(core_stby && !wake_irq, "R12 tick ignored when timer off", {core_stby, wake_irq}, 2'b10);
    ack();
    chk(hold_en && pin_drv == 8'h3C, "R10 ack ignored in stop", {hold_en, pin_drv}, {1'b1, 8'h3C});
    irq_pol_high = 1; irq_en = 1; irq_pin = 1;
    tick();
    irq_en = 0; irq_pol_high = 0;
    chk(wake_irq && !por_req && core_on && !hold_en, "R12 shallow irq wake",
        {wake_irq, por_req, core_on, hold_en}, 4'b1010);
    tick();
    chk(!wake_irq, "R12 wake pulse one cycle", wake_irq, 0);

    // partial ignored when power-down clear
    do_stop(0, 1, 0, 0, 0, 1, lvl);
    chk(core_stby && timer_on && !clk_on, "R2 partial ignored", {core_stby, timer_on, clk_on}, 3'b110);
    rst_pin_n = 0;
    tick();
    rst_pin_n = 1;
    chk(wake_irq && !por_req, "R12 reset pin wakes shallow", {wake_irq, por_req}, 2'b10);

    // random mix
    for (int i = 0; i < 40; i++) begin
      bit pd, pp, le, lse, osc, tmr;
      pd = 1'($urandom); pp = 1'($urandom); le = 1'($urandom); lse = 1'($urandom);
      osc = 1'($urandom); tmr = 1'($urandom);
      held = 8'($urandom);
      port_out = held;
      tick();
      do_stop(pd, pp, le, lse, osc, tmr, lvl);
      port_out = ~held;
      tick();
      if (lvl != 1) chk(pin_drv == held, "R8 random hold", pin_drv, held);
      rst_pin_n = 0;
      tick();
      rst_pin_n = 1;
      chk(por_req == (lvl != 3) && wake_irq == (lvl == 3), "R9 R12 random wake kind",
          {por_req, wake_irq}, {lvl != 3, lvl == 3});
      chk(hold_en == (lvl == 2), "R10 random hold after wake", hold_en, lvl == 2);
      if (hold_en) ack();
      tick();
      chk(act_pwr() == exp_pwr(0, 0, 0) && pin_drv == ~held, "R1 random back to run", pin_drv, ~held);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule